// File: doc/BRIEF.md
# Fully Linked Single-Instruction Processor Core

This core runs programs made of one instruction only: subtract, then branch. Each instruction is four 16-bit words at consecutive addresses. The first two words point at operand A and operand B. The third word is the target taken when the result is zero or negative, and the fourth is the target taken when the result is positive. The core reads both operands, stores B minus A back at B, and loads the program counter from one of the two targets. The program counter never steps to the following instruction by itself.

Words are 16-bit two's complement. The subtraction adds B to the negation of A, and the negation is formed as the inverted A plus one. The sign bit and a zero test of the stored value choose the branch. A selected target of all ones stops the core, and it stays stopped until reset. After reset the core waits for a start pulse. On that pulse it begins at the address presented on `start_addr`.

Memory is reached through one request channel that uses a valid/ready handshake. A request is accepted on any clock edge where `mem_req_valid` and `mem_req_ready` are both high. While a request waits for ready, the core holds its address, write flag and write data unchanged, so the memory may stall the core for any number of cycles. Read data must appear on `mem_rsp_rdata` in the cycle right after the read was accepted. The core has no response handshake. Only one access is outstanding at any time.

Top module: `subleq_core`

## Requirements
- R1: After reset `halted` is low and no request is issued until a one-cycle `start` pulse. The first fetch is at the `start_addr` value sampled with that pulse. `start` has no effect while a program runs or after it halts.
- R2: Each instruction causes exactly seven accepted accesses, in this order: reads at PC, PC+1, PC+2 and PC+3; a read at the A pointer (word 0); a read at the B pointer (word 1); then one write at the B pointer.
- R3: The written value is mem[B] + (~mem[A] + 1), taken modulo 2^16.
- R4: When the written value is zero or negative as a signed 16-bit number, the next fetch starts at the address in word 2.
- R5: When the written value is positive, the next fetch starts at the address in word 3 and never at PC+4.
- R6: When the selected target is 0xFFFF, `halted` goes high and stays high until reset, and no further request is issued.
- R7: While `mem_req_valid` is high and `mem_req_ready` is low, the address, write flag and write data stay stable. Read data is taken exactly one cycle after the read is accepted.
- R8: An instruction whose A and B pointers are equal writes zero and takes the word 2 target.
- R9: Signed overflow wraps, and the sign of the stored value decides the branch. For example, 0x7FFF minus 0xFFFF stores 0x8000 and takes the word 2 target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins execution |
| start_addr | input | 16 | Address of the first instruction, sampled with `start` |
| halted | output | 1 | High once a target of 0xFFFF has been taken |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_we | output | 1 | 1 for a write, 0 for a read |
| mem_req_addr | output | 16 | Word address of the request |
| mem_req_wdata | output | 16 | Data to write |
| mem_rsp_rdata | input | 16 | Read data, valid the cycle after the read is accepted |

## Verification
The assertions check these properties on every cycle:
- a stalled request stays stable;
- the core stays quiet and halted once it has halted;
- the fetch addresses step by one within an instruction;
- the first fetch uses the sampled start address;
- an instruction with equal A and B pointers writes zero.

The right result value and the right branch choice depend on memory contents, so only the bench scenarios can show them. The bench compares the full access trace against an independent model. Its scenarios cover:
- a countdown loop closed by the positive target;
- a trap instruction placed at PC+4;
- an overflow case;
- halts through either target;
- random back-pressure;
- start pulses sent while the core runs or is halted.

// File: rtl/subleq_pkg.sv
package subleq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FA,
    ST_FB,
    ST_FC,
    ST_FD,
    ST_RA,
    ST_RB,
    ST_WR,
    ST_UPD,
    ST_HALT
  } core_state_e;

  // Destination of a read response; the value is the index of the capture register.
  typedef enum logic [2:0] {
    SL_PA = 3'd0,
    SL_PB = 3'd1,
    SL_LE = 3'd2,
    SL_GT = 3'd3,
    SL_VA = 3'd4,
    SL_VB = 3'd5
  } slot_e;

  localparam int unsigned NUM_SLOTS = 6;

endpackage

// File: rtl/subleq_alu.sv
module subleq_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic [DW-1:0] diff,
  output logic          le_zero
);

  logic [DW-1:0] neg_a;

  always_comb begin
    neg_a   = ~opa + DW'(1);
    diff    = opb + neg_a;
    le_zero = diff[DW-1] | ~(|diff);
  end

endmodule

// File: rtl/subleq_operands.sv
module subleq_operands
  import subleq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_acc,
  input  slot_e         rd_slot,
  input  logic [DW-1:0] rsp_data,
  output logic [DW-1:0] ptr_a,
  output logic [DW-1:0] ptr_b,
  output logic [DW-1:0] tgt_le,
  output logic [DW-1:0] tgt_gt,
  output logic [DW-1:0] val_a,
  output logic [DW-1:0] val_b
);

  logic          pend_q;
  slot_e         slot_q;
  logic [DW-1:0] word_q [NUM_SLOTS];

  // The response arrives one cycle after acceptance, so remember where it goes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      slot_q <= SL_PA;
    end else begin
      pend_q <= rd_acc;
      slot_q <= rd_slot;
    end
  end

  for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q[gi] <= '0;
      else if (pend_q && (int'(slot_q) == gi))
        word_q[gi] <= rsp_data;
    end
  end

  assign ptr_a  = word_q[int'(SL_PA)];
  assign ptr_b  = word_q[int'(SL_PB)];
  assign tgt_le = word_q[int'(SL_LE)];
  assign tgt_gt = word_q[int'(SL_GT)];
  assign val_a  = word_q[int'(SL_VA)];
  // B may be needed in the cycle its response lands: forward it.
  assign val_b  = (pend_q && slot_q == SL_VB) ? rsp_data : word_q[int'(SL_VB)];

endmodule

// File: rtl/subleq_fsm.sv
module subleq_fsm
  import subleq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] start_addr,
  input  logic          req_ready,
  input  logic [DW-1:0] ptr_a,
  input  logic [DW-1:0] ptr_b,
  input  logic [DW-1:0] tgt_le,
  input  logic [DW-1:0] tgt_gt,
  input  logic [DW-1:0] diff,
  input  logic          le_zero,
  output logic          req_valid,
  output logic          req_we,
  output logic [DW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  output logic          rd_acc,
  output slot_e         rd_slot,
  output logic          halted
);

  localparam logic [DW-1:0] STOP_ADDR = '1;

  core_state_e   st_q, st_d;
  logic [DW-1:0] pc_q;
  logic          le_q;
  logic          accept;
  logic [DW-1:0] next_pc;

  assign accept  = req_valid && req_ready;
  assign next_pc = le_q ? tgt_le : tgt_gt;
  assign rd_acc  = accept && !req_we;
  assign halted  = (st_q == ST_HALT);

  // Request generation: one access per state.
  always_comb begin
    req_valid = 1'b0;
    req_we    = 1'b0;
    req_addr  = pc_q;
    req_wdata = '0;
    rd_slot   = SL_PA;
    unique case (st_q)
      ST_FA: begin req_valid = 1'b1; req_addr = pc_q;          rd_slot = SL_PA; end
      ST_FB: begin req_valid = 1'b1; req_addr = pc_q + DW'(1); rd_slot = SL_PB; end
      ST_FC: begin req_valid = 1'b1; req_addr = pc_q + DW'(2); rd_slot = SL_LE; end
      ST_FD: begin req_valid = 1'b1; req_addr = pc_q + DW'(3); rd_slot = SL_GT; end
      ST_RA: begin req_valid = 1'b1; req_addr = ptr_a;         rd_slot = SL_VA; end
      ST_RB: begin req_valid = 1'b1; req_addr = ptr_b;         rd_slot = SL_VB; end
      ST_WR: begin
        req_valid = 1'b1;
        req_we    = 1'b1;
        req_addr  = ptr_b;
        req_wdata = diff;
      end
      default: ;
    endcase
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start)  st_d = ST_FA;
      ST_FA:   if (accept) st_d = ST_FB;
      ST_FB:   if (accept) st_d = ST_FC;
      ST_FC:   if (accept) st_d = ST_FD;
      ST_FD:   if (accept) st_d = ST_RA;
      ST_RA:   if (accept) st_d = ST_RB;
      ST_RB:   if (accept) st_d = ST_WR;
      ST_WR:   if (accept) st_d = ST_UPD;
      ST_UPD:  st_d = (next_pc == STOP_ADDR) ? ST_HALT : ST_FA;
      default: st_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      pc_q <= '0;
      le_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE)
        pc_q <= start_addr;
      else if (st_q == ST_UPD && next_pc != STOP_ADDR)
        pc_q <= next_pc;
      if (st_q == ST_WR && accept)
        le_q <= le_zero;
    end
  end

  // R7: a request waiting for ready keeps its content
  p_hold_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_we)
                                && $stable(req_wdata));

  // R6: halt is final and silent
  p_halt_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && !req_valid);

  // R8: equal pointers always store zero
  p_same_ptr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_we && (ptr_a == ptr_b) |-> req_wdata == '0);

  // R1: first fetch after idle goes to the start address sampled with start
  p_start_pc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) && $past(st_q == ST_IDLE) |-> req_addr == $past(start_addr));

  // R2: pointer fetches walk upward one word at a time
  p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (st_q == ST_FA || st_q == ST_FB || st_q == ST_FC)
      |=> req_addr == $past(req_addr) + DW'(1));

endmodule

// File: rtl/subleq_core.sv
module subleq_core
  import subleq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] start_addr,
  output logic          halted,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [DW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic [DW-1:0] mem_rsp_rdata
);

  logic          rd_acc;
  slot_e         rd_slot;
  logic [DW-1:0] ptr_a, ptr_b, tgt_le, tgt_gt, val_a, val_b;
  logic [DW-1:0] diff;
  logic          le_zero;

  subleq_operands #(.DW(DW)) u_operands (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_acc   (rd_acc),
    .rd_slot  (rd_slot),
    .rsp_data (mem_rsp_rdata),
    .ptr_a    (ptr_a),
    .ptr_b    (ptr_b),
    .tgt_le   (tgt_le),
    .tgt_gt   (tgt_gt),
    .val_a    (val_a),
    .val_b    (val_b)
  );

  subleq_alu #(.DW(DW)) u_alu (
    .opa     (val_a),
    .opb     (val_b),
    .diff    (diff),
    .le_zero (le_zero)
  );

  subleq_fsm #(.DW(DW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (start_addr),
    .req_ready  (mem_req_ready),
    .ptr_a      (ptr_a),
    .ptr_b      (ptr_b),
    .tgt_le     (tgt_le),
    .tgt_gt     (tgt_gt),
    .diff       (diff),
    .le_zero    (le_zero),
    .req_valid  (mem_req_valid),
    .req_we     (mem_req_we),
    .req_addr   (mem_req_addr),
    .req_wdata  (mem_req_wdata),
    .rd_acc     (rd_acc),
    .rd_slot    (rd_slot),
    .halted     (halted)
  );

endmodule

// File: tb/subleq_core_tb.sv
module subleq_core_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] start_addr = '0;
  logic        halted;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_we;
  logic [15:0] mem_req_addr;
  logic [15:0] mem_req_wdata;
  logic [15:0] mem_rsp_rdata = 16'hDEAD;

  always #4 clk = ~clk;

  subleq_core u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .start_addr    (start_addr),
    .halted        (halted),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_rdata (mem_rsp_rdata)
  );

  typedef struct {
    bit          we;
    logic [15:0] addr;
    logic [15:0] data;
    string       tag;
  } acc_t;

  acc_t        exp_q[$];
  logic [15:0] mem     [256];
  logic [15:0] ref_mem [256];
  int          total = 0;
  int          bad = 0;
  bit          stall_en = 0;
  bit          done = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Memory model and monitor: sample just after the falling edge.
  initial begin
    bit          pend_v = 0;
    logic [15:0] pend_d = '0;
    bit          prev_stall = 0;
    logic [15:0] prev_addr = '0, prev_wdata = '0;
    bit          prev_we = 0;
    forever begin
      @(negedge clk);
      mem_rsp_rdata = pend_v ? pend_d : 16'hDEAD;
      pend_v = 0;
      #1;
      if (!rst_n) begin
        mem_req_ready = 0;
        prev_stall = 0;
      end else begin
        if (prev_stall)
          check(mem_req_valid && mem_req_addr == prev_addr && mem_req_we == prev_we &&
                mem_req_wdata == prev_wdata, "R7", "stalled request changed",
                mem_req_addr, prev_addr);
        mem_req_ready = stall_en ? ($urandom_range(0, 2) != 0) : 1'b1;
        if (mem_req_valid && mem_req_ready) begin
          if (exp_q.size() == 0) begin
            check(0, "R6", "access with none expected", mem_req_addr, 16'h0000);
          end else begin
            acc_t it;
            it = exp_q.pop_front();
            check(mem_req_we == it.we && mem_req_addr == it.addr, it.tag,
                  "access address", mem_req_addr, it.addr);
            if (it.we)
              check(mem_req_wdata == it.data, it.tag, "write data", mem_req_wdata, it.data);
          end
          if (mem_req_we) begin
            mem[mem_req_addr[7:0]] = mem_req_wdata;
          end else begin
            pend_d = mem[mem_req_addr[7:0]];
            pend_v = 1;
          end
        end
        prev_stall = mem_req_valid && !mem_req_ready;
        prev_addr  = mem_req_addr;
        prev_we    = mem_req_we;
        prev_wdata = mem_req_wdata;
      end
    end
  end

  // Driver: independent model that queues the expected access trace.
  task automatic run_ref(input logic [15:0] start_pc);
    logic [15:0] pc = start_pc;
    string       arrive = "R1";
    for (int step = 0; step < 300; step++) begin
      logic [15:0] pa, pb, c, d, va, vb, res, nxt;
      bit          le;
      pa = ref_mem[pc[7:0]];
      pb = ref_mem[8'(pc + 16'd1)];
      c  = ref_mem[8'(pc + 16'd2)];
      d  = ref_mem[8'(pc + 16'd3)];
      exp_q.push_back('{0, pc, 16'h0, arrive});
      exp_q.push_back('{0, pc + 16'd1, 16'h0, "R2"});
      exp_q.push_back('{0, pc + 16'd2, 16'h0, "R2"});
      exp_q.push_back('{0, pc + 16'd3, 16'h0, "R2"});
      exp_q.push_back('{0, pa, 16'h0, "R2"});
      exp_q.push_back('{0, pb, 16'h0, "R2"});
      va  = ref_mem[pa[7:0]];
      vb  = ref_mem[pb[7:0]];
      res = vb + (~va + 16'd1);
      le  = res[15] || (res == 16'h0);
      exp_q.push_back('{1, pb, res, (pa == pb) ? "R8" : "R3"});
      ref_mem[pb[7:0]] = res;
      nxt = le ? c : d;
      if (pa == pb) arrive = "R8";
      else if (va[15] != vb[15] && res[15] != vb[15]) arrive = "R9";
      else arrive = le ? "R4" : "R5";
      if (nxt == 16'hFFFF) break;
      pc = nxt;
    end
  endtask

  task automatic put(input logic [7:0] a, input logic [15:0] v);
    mem[a] = v;
    ref_mem[a] = v;
  endtask

  task automatic put_ins(input logic [7:0] at, input logic [15:0] a, b, c, d);
    put(at, a); put(at + 8'd1, b); put(at + 8'd2, c); put(at + 8'd3, d);
  endtask

  task automatic load_prog();
    for (int i = 0; i < 256; i++) put(8'(i), 16'h0);
    put_ins(8'd0,  16'h81, 16'h80, 16'd8,  16'd0);      // countdown, loops via word 3
    put_ins(8'd4,  16'h81, 16'h82, 16'hFFFF, 16'hFFFF); // trap at PC+4
    put_ins(8'd8,  16'h83, 16'h83, 16'd12, 16'hFFFF);   // A == B
    put_ins(8'd12, 16'h84, 16'h85, 16'd16, 16'hFFFF);   // overflow
    put_ins(8'd16, 16'h86, 16'h87, 16'd20, 16'hFFFF);   // negative result
    put_ins(8'd20, 16'h88, 16'h89, 16'd0,  16'hFFFF);   // positive, halt
    put_ins(8'd24, 16'h81, 16'h8A, 16'hFFFF, 16'd0);    // negative, halt
    put(8'h80, 16'd3);    put(8'h81, 16'd1);   put(8'h82, 16'h5A5A);
    put(8'h83, 16'h1234); put(8'h84, 16'hFFFF); put(8'h85, 16'h7FFF);
    put(8'h86, 16'd5);    put(8'h87, 16'd2);   put(8'h88, 16'd1);
    put(8'h89, 16'd10);   put(8'h8A, 16'd0);
  endtask

  task automatic do_reset();
    rst_n = 0;
    start = 0;
    exp_q.delete();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_halt();
    int n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
    #2;
    check(halted, "R6", "halted after stop target", 16'(halted), 16'h1);
    check(exp_q.size() == 0, "R2", "accesses left unmade", 16'(exp_q.size()), 16'h0);
    pulse_start();                                   // R1: start after halt ignored
    repeat (10) @(negedge clk);
    #2;
    check(halted && !mem_req_valid, "R6", "halt held and silent", 16'(halted), 16'h1);
  endtask

  initial begin
    #(8 * 150000);
    check(0, "R6", "watchdog expired", 16'h0, 16'h1);
    finish_up();
  end

  initial begin
    do_reset();
    #2;
    check(!halted, "R1", "halted after reset", 16'(halted), 16'h0);
    check(!mem_req_valid, "R1", "request after reset", 16'(mem_req_valid), 16'h0);
    repeat (6) @(negedge clk);
    #2;
    check(!mem_req_valid, "R1", "request without start", 16'(mem_req_valid), 16'h0);

    // Run 1: whole program from 0, no back-pressure.
    load_prog();
    start_addr = 16'd0;
    run_ref(16'd0);
    pulse_start();
    start_addr = 16'h00F0;
    wait_halt();
    check(mem[8'h80] == 16'h0,    "R4", "countdown end value", mem[8'h80], 16'h0);
    check(mem[8'h82] == 16'h5A5A, "R5", "trap at PC+4 touched", mem[8'h82], 16'h5A5A);
    check(mem[8'h83] == 16'h0,    "R8", "equal pointer result", mem[8'h83], 16'h0);
    check(mem[8'h85] == 16'h8000, "R9", "overflow result", mem[8'h85], 16'h8000);
    check(mem[8'h87] == 16'hFFFD, "R3", "negative result", mem[8'h87], 16'hFFFD);
    check(mem[8'h89] == 16'd9,    "R5", "positive result", mem[8'h89], 16'd9);

    // Run 2: start mid-program with back-pressure and a stray start pulse.
    do_reset();
    load_prog();
    stall_en = 1;
    start_addr = 16'd8;
    run_ref(16'd8);
    pulse_start();
    start_addr = 16'd24;
    repeat (9) @(negedge clk);
    pulse_start();                                   // R1: ignored while running
    wait_halt();
    for (int i = 8'h83; i <= 8'h89; i++)
      check(mem[i] == ref_mem[i], "R7", "memory after stalled run", mem[i], ref_mem[i]);

    // Run 3: halt reached through the word 2 target.
    do_reset();
    load_prog();
    start_addr = 16'd24;
    run_ref(16'd24);
    pulse_start();
    wait_halt();
    check(mem[8'h8A] == 16'hFFFF, "R4", "halt via word 2 result", mem[8'h8A], 16'hFFFF);

    finish_up();
  end

endmodule